// File: doc/BRIEF.md
# Region-Splitting Wishbone Master Bridge

This block sits between a simple host request port and the rest of a chip's address space. The host presents one access at a time: a 32-bit byte address, write data, four byte enables and a write flag. The bridge decodes the top address byte and sends the access to one of three destinations. The lowest 16 MB selects a tightly coupled RAM that the host drives directly. The highest 16 MB goes to a Wishbone peripheral master with a 24-bit address. All addresses between those two windows go to a Wishbone memory master with a full 32-bit address. The last 256 bytes of the peripheral window are kept back for fixed startup code, and the bridge drops any access to them.

While a Wishbone cycle is open, the bridge holds a wait request toward the host. An access ends in one of two ways. If the slave acknowledges, the bridge returns the captured read data. If no acknowledge arrives within a programmable number of clocks (4096 by default), the bridge closes the cycle itself and returns an error flag. The system reset is passed to both ports as their own reset outputs, and it also aborts any cycle in progress.

Top module: `wbsplit_bridge`

## Requirements
- R1: An accepted request with address 0000_0000h..00FF_FFFFh raises `ram_sel` in the same cycle, combinationally. It opens no Wishbone cycle and leaves `host_wait` low.
- R2: An accepted request with address 0100_0000h..FEFF_FFFFh opens a cycle on the memory port. That port drives the full 32-bit address, the write data, the byte enables and the write flag (1 = write, 0 = read).
- R3: An accepted request with address FF00_0000h..FFFF_FEFFh opens a cycle on the peripheral port, which drives address bits 23..0 of the request.
- R4: A request with address FFFF_FF00h..FFFF_FFFFh never appears on either port. The bridge completes it with `rsp_valid` high in the cycle after acceptance, `rsp_err` = 0 and `rsp_rdata` = 0.
- R5: CYC and STB rise together in the cycle after acceptance. They stay high, with address, data, select and WE unchanged, until ACK is sampled high. Both are low in the next cycle.
- R6: The select output copies the request's byte enables unchanged. Bit i marks data bits 8i+7..8i as valid, so bit 0 covers 7..0 and bit 3 covers 31..24.
- R7: `host_wait` is high in exactly those cycles in which either port has CYC high.
- R8: On a read, the port's DAT_I is captured in the cycle in which ACK is high. It appears on `rsp_rdata` with `rsp_valid` high and `rsp_err` low in the next cycle. A write returns `rsp_rdata` = 0.
- R9: If ACK has not arrived after CYC has been high for TIMEOUT_CYCLES clocks, CYC and STB drop and `host_wait` is released. The next cycle carries `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0.
- R10: At most one port has CYC high at a time. A request presented while the bridge is busy is ignored: it opens no cycle and raises no `ram_sel`.
- R11: `mem_rst` and `per_rst` follow `rst`. Asserting `rst` during a cycle forces CYC low at the next edge and produces no response.
- R12: The timeout count restarts on every accepted access. An access that follows a timed-out access, and that is acknowledged just before the limit, completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| req_valid | input | 1 | Host request strobe |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_be | input | 4 | Host byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| host_wait | output | 1 | Wait request toward the host |
| ram_sel | output | 1 | Internal RAM select |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion ended by timeout |
| rsp_rdata | output | 32 | Read data of the completed access |
| mem_cyc | output | 1 | Memory port cycle |
| mem_stb | output | 1 | Memory port strobe |
| mem_we | output | 1 | Memory port write enable |
| mem_adr | output | 32 | Memory port address |
| mem_dat_o | output | 32 | Memory port write data |
| mem_sel | output | 4 | Memory port byte select |
| mem_ack | input | 1 | Memory port acknowledge |
| mem_dat_i | input | 32 | Memory port read data |
| mem_rst | output | 1 | Memory port reset |
| per_cyc | output | 1 | Peripheral port cycle |
| per_stb | output | 1 | Peripheral port strobe |
| per_we | output | 1 | Peripheral port write enable |
| per_adr | output | 24 | Peripheral port address |
| per_dat_o | output | 32 | Peripheral port write data |
| per_sel | output | 4 | Peripheral port byte select |
| per_ack | input | 1 | Peripheral port acknowledge |
| per_dat_i | input | 32 | Peripheral port read data |
| per_rst | output | 1 | Peripheral port reset |

## Verification
The hardest case to reach from the ports is the edge of the timeout. An access must be held open for the full limit. A second access must then be acknowledged one clock before that limit, to show that the count was cleared rather than carried over. The bench's slave models take a delay for each access, where a negative value means "never acknowledge". This lets the stimulus leave one cycle to expire, then schedule the next acknowledge at TIMEOUT_CYCLES−1 clocks. Requests presented while the bridge is busy, and a reset asserted in the middle of a cycle, are injected while a slow slave holds the cycle open.

// File: rtl/wbsplit_pkg.sv
package wbsplit_pkg;
   typedef enum logic [1:0] {
      DST_RAM  = 2'd0,
      DST_MEM  = 2'd1,
      DST_PER  = 2'd2,
      DST_BOOT = 2'd3
   } dest_e;
endpackage

// File: rtl/wbsplit_decode.sv
module wbsplit_decode
   import wbsplit_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIN_LSB  = 24,
   parameter int BOOT_LSB = 8
) (
   input  logic [ADDR_W-1:BOOT_LSB] addr_hi,
   output dest_e                    dest
);
   localparam int TOP_W = ADDR_W - WIN_LSB;
   localparam int MID_W = WIN_LSB - BOOT_LSB;

   generate
      if (TOP_W < 2) begin : g_bad_top
         $error("wbsplit_decode: region field too narrow");
      end
      if (MID_W < 1) begin : g_bad_mid
         $error("wbsplit_decode: reserved window must be below region boundary");
      end
   endgenerate

   logic [TOP_W-1:0] top_field;
   logic [MID_W-1:0] mid_field;

   assign top_field = addr_hi[ADDR_W-1:WIN_LSB];
   assign mid_field = addr_hi[WIN_LSB-1:BOOT_LSB];

   always_comb begin
      if (top_field == '0) begin
         dest = DST_RAM;
      end else if (&top_field) begin
         dest = (&mid_field) ? DST_BOOT : DST_PER;
      end else begin
         dest = DST_MEM;
      end
   end
endmodule

// File: rtl/wbsplit_timer.sv
module wbsplit_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("wbsplit_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (run && !expired) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

   // R12
   cnt_cleared_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> cnt == '0);
endmodule

// File: rtl/wbsplit_port.sv
module wbsplit_port #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int SW = DW / 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          launch,
   input  logic          abort,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] wdata_in,
   input  logic [SW-1:0] sel_in,
   input  logic          we_in,
   input  logic          ack_i,
   output logic          cyc_o,
   output logic          stb_o,
   output logic          we_o,
   output logic [AW-1:0] adr_o,
   output logic [DW-1:0] dat_o,
   output logic [SW-1:0] sel_o,
   output logic          done
);
   generate
      if (SW * 8 != DW) begin : g_bad_sel
         $error("wbsplit_port: data width must be a whole number of bytes");
      end
   endgenerate

   logic active;

   assign cyc_o = active;
   assign stb_o = active;
   assign done  = active && ack_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
      end else if (launch) begin
         active <= 1'b1;
      end else if (active && (ack_i || abort)) begin
         active <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         adr_o <= '0;
         dat_o <= '0;
         sel_o <= '0;
         we_o  <= 1'b0;
      end else if (launch) begin
         adr_o <= addr_in;
         dat_o <= wdata_in;
         sel_o <= sel_in;
         we_o  <= we_in;
      end
   end

   // R5
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_o && !ack_i && !abort |=> cyc_o && $stable(adr_o) && $stable(dat_o)
                                      && $stable(sel_o) && $stable(we_o));

   // R5
   drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_o && ack_i |=> !cyc_o);

   // R5
   open_after_launch_chk: assert property (@(posedge clk) disable iff (rst)
      launch |=> cyc_o && stb_o);
endmodule

// File: rtl/wbsplit_bridge.sv
module wbsplit_bridge
   import wbsplit_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter int WIN_LSB        = 24,
   parameter int BOOT_LSB       = 8,
   parameter int TIMEOUT_CYCLES = 4096
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic                req_write,
   output logic                host_wait,
   output logic                ram_sel,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                mem_cyc,
   output logic                mem_stb,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_adr,
   output logic [DATA_W-1:0]   mem_dat_o,
   output logic [DATA_W/8-1:0] mem_sel,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_dat_i,
   output logic                mem_rst,
   output logic                per_cyc,
   output logic                per_stb,
   output logic                per_we,
   output logic [WIN_LSB-1:0]  per_adr,
   output logic [DATA_W-1:0]   per_dat_o,
   output logic [DATA_W/8-1:0] per_sel,
   input  logic                per_ack,
   input  logic [DATA_W-1:0]   per_dat_i,
   output logic                per_rst
);
   localparam int SEL_W  = DATA_W / 8;
   localparam int PER_AW = WIN_LSB;

   generate
      if (ADDR_W <= WIN_LSB) begin : g_bad_win
         $error("wbsplit_bridge: peripheral window must be smaller than address space");
      end
      if (BOOT_LSB >= WIN_LSB) begin : g_bad_boot
         $error("wbsplit_bridge: reserved window must sit inside peripheral window");
      end
   endgenerate

   dest_e dest;
   logic  busy, accept;
   logic  go_mem, go_per, boot_hit;
   logic  mem_done, per_done, ack_hit;
   logic  expired, abort;
   logic  cur_we;
   logic [DATA_W-1:0] cur_dat;

   wbsplit_decode #(
      .ADDR_W  (ADDR_W),
      .WIN_LSB (WIN_LSB),
      .BOOT_LSB(BOOT_LSB)
   ) i_decode (
      .addr_hi(req_addr[ADDR_W-1:BOOT_LSB]),
      .dest   (dest)
   );

   assign busy     = mem_cyc || per_cyc;
   assign accept   = req_valid && !busy;
   assign ram_sel  = accept && (dest == DST_RAM);
   assign go_mem   = accept && (dest == DST_MEM);
   assign go_per   = accept && (dest == DST_PER);
   assign boot_hit = accept && (dest == DST_BOOT);
   assign host_wait = busy;

   assign mem_rst = rst;
   assign per_rst = rst;

   wbsplit_port #(
      .AW(ADDR_W),
      .DW(DATA_W)
   ) i_mem_port (
      .clk     (clk),
      .rst     (rst),
      .launch  (go_mem),
      .abort   (abort),
      .addr_in (req_addr),
      .wdata_in(req_wdata),
      .sel_in  (req_be),
      .we_in   (req_write),
      .ack_i   (mem_ack),
      .cyc_o   (mem_cyc),
      .stb_o   (mem_stb),
      .we_o    (mem_we),
      .adr_o   (mem_adr),
      .dat_o   (mem_dat_o),
      .sel_o   (mem_sel),
      .done    (mem_done)
   );

   wbsplit_port #(
      .AW(PER_AW),
      .DW(DATA_W)
   ) i_per_port (
      .clk     (clk),
      .rst     (rst),
      .launch  (go_per),
      .abort   (abort),
      .addr_in (req_addr[PER_AW-1:0]),
      .wdata_in(req_wdata),
      .sel_in  (req_be),
      .we_in   (req_write),
      .ack_i   (per_ack),
      .cyc_o   (per_cyc),
      .stb_o   (per_stb),
      .we_o    (per_we),
      .adr_o   (per_adr),
      .dat_o   (per_dat_o),
      .sel_o   (per_sel),
      .done    (per_done)
   );

   wbsplit_timer #(
      .LIMIT(TIMEOUT_CYCLES)
   ) i_timer (
      .clk    (clk),
      .rst    (rst),
      .clr    (accept),
      .run    (busy),
      .expired(expired)
   );

   assign ack_hit = mem_done || per_done;
   assign abort   = expired && !ack_hit;
   assign cur_we  = mem_cyc ? mem_we : per_we;
   assign cur_dat = mem_cyc ? mem_dat_i : per_dat_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= ack_hit || abort || boot_hit;
         rsp_err   <= abort;
         rsp_rdata <= (ack_hit && !cur_we) ? cur_dat : '0;
      end
   end

   // R10
   one_port_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_cyc && per_cyc));

   // R4
   boot_hidden_chk: assert property (@(posedge clk) disable iff (rst)
      per_cyc |-> !(&per_adr[PER_AW-1:BOOT_LSB]));

   // R8
   ack_reply_chk: assert property (@(posedge clk) disable iff (rst)
      ack_hit |=> rsp_valid && !rsp_err);

   // R9
   timeout_reply_chk: assert property (@(posedge clk) disable iff (rst)
      abort |=> rsp_valid && rsp_err && (rsp_rdata == '0) && !host_wait);

   // R11
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> !mem_cyc && !per_cyc && !rsp_valid);
endmodule

// File: tb/test_wbsplit_bridge.sv
module test_wbsplit_bridge;
   localparam int TMO = 4096;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        req_write = 1'b0;
   logic        host_wait, ram_sel, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        mem_cyc, mem_stb, mem_we, mem_rst;
   logic [31:0] mem_adr, mem_dat_o;
   logic [3:0]  mem_sel;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_dat_i = '0;
   logic        per_cyc, per_stb, per_we, per_rst;
   logic [23:0] per_adr;
   logic [31:0] per_dat_o;
   logic [3:0]  per_sel;
   logic        per_ack = 1'b0;
   logic [31:0] per_dat_i = '0;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   int          mem_delay = 0, per_delay = 0;
   logic [31:0] mem_rd = '0, per_rd = '0;
   int          mcnt = 0, pcnt = 0;

   logic [32:0] exp_q[$];

   wbsplit_bridge i_wbsplit_bridge (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
      .host_wait(host_wait), .ram_sel(ram_sel), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .mem_cyc(mem_cyc), .mem_stb(mem_stb), .mem_we(mem_we), .mem_adr(mem_adr),
      .mem_dat_o(mem_dat_o), .mem_sel(mem_sel), .mem_ack(mem_ack),
      .mem_dat_i(mem_dat_i), .mem_rst(mem_rst),
      .per_cyc(per_cyc), .per_stb(per_stb), .per_we(per_we), .per_adr(per_adr),
      .per_dat_o(per_dat_o), .per_sel(per_sel), .per_ack(per_ack),
      .per_dat_i(per_dat_i), .per_rst(per_rst)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // slave models: delay < 0 means never acknowledge
   always @(negedge clk) begin
      if (!mem_cyc || mem_ack) begin
         mem_ack = 1'b0;
         mcnt = 0;
      end else begin
         if (mem_delay >= 0 && mcnt == mem_delay) begin
            mem_ack = 1'b1;
            mem_dat_i = mem_rd;
         end
         mcnt++;
      end
      if (!per_cyc || per_ack) begin
         per_ack = 1'b0;
         pcnt = 0;
      end else begin
         if (per_delay >= 0 && pcnt == per_delay) begin
            per_ack = 1'b1;
            per_dat_i = per_rd;
         end
         pcnt++;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected response", {31'd0, rsp_valid}, 32'd0);
         end else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            chk(rsp_err === e[32], "R9", "response error flag", {31'd0, rsp_err}, {31'd0, e[32]});
            chk(rsp_rdata === e[31:0], "R8", "response data", rsp_rdata, e[31:0]);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic int kind(input logic [31:0] a);
      if (a[31:24] == 8'h00) return 0;
      if (a[31:24] != 8'hFF) return 1;
      if (a[23:8] == 16'hFFFF) return 3;
      return 2;
   endfunction

   // issue one access from a negedge, return at the negedge after completion
   task automatic access(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be,
                         input logic we, input int dly, input logic [31:0] rd, output int held);
      int k;
      k = kind(a);
      held = 0;
      if (k == 1) begin mem_delay = dly; mem_rd = rd; end
      if (k == 2) begin per_delay = dly; per_rd = rd; end
      if (k == 1 || k == 2)
         exp_q.push_back({(dly < 0), (we || dly < 0) ? 32'd0 : rd});
      if (k == 3)
         exp_q.push_back(33'd0);
      req_addr = a; req_wdata = wd; req_be = be; req_write = we; req_valid = 1'b1;
      #1;
      if (k == 0) begin
         chk(ram_sel === 1'b1, "R1", "ram_sel", {31'd0, ram_sel}, 32'd1);
         chk(host_wait === 1'b0, "R1", "host_wait on RAM", {31'd0, host_wait}, 32'd0);
      end else begin
         chk(ram_sel === 1'b0, "R1", "ram_sel off-region", {31'd0, ram_sel}, 32'd0);
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (k == 1) begin
         chk(mem_cyc && mem_stb, "R5", "mem cyc/stb", {30'd0, mem_cyc, mem_stb}, 32'd3);
         chk(mem_adr === a, "R2", "mem address", mem_adr, a);
         chk(mem_dat_o === wd, "R2", "mem write data", mem_dat_o, wd);
         chk(mem_we === we, "R2", "mem we", {31'd0, mem_we}, {31'd0, we});
         chk(mem_sel === be, "R6", "mem select", {28'd0, mem_sel}, {28'd0, be});
         chk(!per_cyc, "R10", "other port idle", {31'd0, per_cyc}, 32'd0);
      end else if (k == 2) begin
         chk(per_cyc && per_stb, "R5", "per cyc/stb", {30'd0, per_cyc, per_stb}, 32'd3);
         chk(per_adr === a[23:0], "R3", "per address", {8'd0, per_adr}, {8'd0, a[23:0]});
         chk(per_we === we, "R3", "per we", {31'd0, per_we}, {31'd0, we});
         chk(per_sel === be, "R6", "per select", {28'd0, per_sel}, {28'd0, be});
         chk(!mem_cyc, "R10", "other port idle", {31'd0, mem_cyc}, 32'd0);
      end else begin
         chk(!mem_cyc && !per_cyc, (k == 3) ? "R4" : "R1", "no port cycle",
             {30'd0, mem_cyc, per_cyc}, 32'd0);
      end
      if (k == 1 || k == 2) begin
         chk(host_wait === 1'b1, "R7", "wait raised", {31'd0, host_wait}, 32'd1);
         held = 1;
         while (host_wait && held < TMO + 10) begin
            @(negedge clk);
            if (host_wait) held++;
         end
         chk(!mem_cyc && !per_cyc, "R5", "cycle closed", {30'd0, mem_cyc, per_cyc}, 32'd0);
      end else begin
         @(negedge clk);
      end
   endtask

   initial begin
      int h;
      repeat (3) @(negedge clk);
      chk(mem_rst === 1'b1 && per_rst === 1'b1, "R11", "port resets follow rst",
          {30'd0, mem_rst, per_rst}, 32'd3);
      chk(!mem_cyc && !per_cyc && !host_wait && !rsp_valid, "R11", "reset state",
          {28'd0, mem_cyc, per_cyc, host_wait, rsp_valid}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(mem_rst === 1'b0 && per_rst === 1'b0, "R11", "port resets released",
          {30'd0, mem_rst, per_rst}, 32'd0);

      // RAM region boundaries
      access(32'h0000_0000, 32'h0, 4'hF, 1'b0, 0, 32'h0, h);
      access(32'h00FF_FFFF, 32'h0, 4'h1, 1'b1, 0, 32'h0, h);

      // memory port reads and writes
      access(32'h0100_0000, 32'h0, 4'hF, 1'b0, 0, 32'hCAFE_0001, h);
      chk(h == 1, "R5", "ack delay 0 cycle length", h, 1);
      access(32'hFEFF_FFFC, 32'h1234_5678, 4'b0011, 1'b1, 3, 32'hFFFF_FFFF, h);
      chk(h == 4, "R7", "wait length delay 3", h, 4);
      access(32'h8000_0040, 32'h0, 4'b1000, 1'b0, 7, 32'hA5A5_5A5A, h);
      chk(h == 8, "R7", "wait length delay 7", h, 8);

      // peripheral port
      access(32'hFF12_3456, 32'h0, 4'b0100, 1'b0, 2, 32'h0BAD_F00D, h);
      access(32'hFFFF_FEFC, 32'hDEAD_BEEF, 4'hF, 1'b1, 1, 32'h0, h);
      access(32'hFF00_0000, 32'h0, 4'b0001, 1'b0, 0, 32'h7700_0077, h);

      // reserved window dropped
      access(32'hFFFF_FF00, 32'h1111_1111, 4'hF, 1'b1, 0, 32'h0, h);
      access(32'hFFFF_FFFF, 32'h0, 4'hF, 1'b0, 0, 32'h0, h);

      // R10: requests while busy are ignored
      mem_delay = 20; mem_rd = 32'h5555_AAAA;
      exp_q.push_back({1'b0, 32'h5555_AAAA});
      req_addr = 32'h0200_0000; req_be = 4'hF; req_write = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      req_addr = 32'hFF00_1000; req_valid = 1'b1;
      #1;
      chk(ram_sel === 1'b0, "R10", "no select while busy", {31'd0, ram_sel}, 32'd0);
      @(negedge clk);
      req_addr = 32'h0000_0010;
      #1;
      chk(ram_sel === 1'b0, "R10", "no RAM select while busy", {31'd0, ram_sel}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!per_cyc && mem_cyc, "R10", "peripheral not opened", {30'd0, mem_cyc, per_cyc}, 32'd2);
      chk(mem_adr === 32'h0200_0000, "R10", "memory cycle unchanged", mem_adr, 32'h0200_0000);
      while (host_wait) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R10", "one response only", exp_q.size(), 0);

      // R9: timeout on memory port
      access(32'h0300_0000, 32'h0, 4'hF, 1'b0, -1, 32'h9999_9999, h);
      chk(h == TMO, "R9", "cycle held until timeout", h, TMO);
      // R12: next access acked just before limit succeeds
      access(32'h0300_0004, 32'h0, 4'hF, 1'b0, TMO - 2, 32'h1357_9BDF, h);
      chk(h == TMO - 1, "R12", "late ack after timeout", h, TMO - 1);
      // R9 on peripheral port
      access(32'hFF00_0100, 32'h1, 4'hF, 1'b1, -1, 32'h0, h);
      chk(h == TMO, "R9", "peripheral timeout", h, TMO);

      // R11: reset mid-cycle
      mem_delay = -1;
      req_addr = 32'h0400_0000; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk(mem_cyc === 1'b1, "R11", "cycle open before reset", {31'd0, mem_cyc}, 32'd1);
      rst = 1'b1;
      #1;
      chk(mem_rst === 1'b1, "R11", "mem_rst follows rst", {31'd0, mem_rst}, 32'd1);
      @(negedge clk);
      chk(!mem_cyc && !host_wait && !rsp_valid, "R11", "reset aborts cycle",
          {29'd0, mem_cyc, host_wait, rsp_valid}, 32'd0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R8", "all responses seen", exp_q.size(), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule